// File: doc/BRIEF.md
# Task-File Shadow Bank with High-Order-Byte History

This block keeps a copy of the eight-bit legacy disk task-file registers for a serial-ATA host channel. Software writes these registers through an I/O port. The block decodes them and stores the bytes. On a command write it hands a fully laid-out host-to-device register FIS to the link layer.

The features, sector count and the three LBA byte registers each keep the two most recent bytes written to them. A 48-bit LBA command loads each register twice: the high-order half first, then the low-order half. A read returns the newer byte by default. It returns the older byte while the high-order-byte select bit (bit 7 of the device control register) is set. The same two-deep storage feeds the FIS, which places the newer bytes in the current fields and the older bytes in the expanded fields. The FIS output is a parallel 20-byte word with a one-cycle send strobe. Framing, CRC, the serial link and any DMA are not part of this block.

Top module: `tf_shadow_bank`

## Requirements
- R1: With `SECONDARY=0` the command block occupies I/O addresses 0x1F1..0x1F7 and device control sits at 0x3F6. With `SECONDARY=1` they are 0x171..0x177 and 0x376. Offsets from the base are: 1 features, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 command.
- R2: A write to features, sector count or an LBA byte register moves that register's newest byte into its older slot and stores the written byte as newest.
- R3: While device control bit 7 is 0, reading one of those five registers returns its newest byte.
- R4: While device control bit 7 is 1, reading one of those five registers returns its older byte.
- R5: A write to device control stores all 8 bits. Bit 7 of the written byte becomes the select bit, so writing bit 7 as 0 clears it. A read of the device control address returns the stored byte.
- R6: The device and command registers hold only the last byte written, and their reads do not depend on the select bit.
- R7: `fis_send_o` is high for exactly the one cycle after each clock edge that takes a command-register write, and for no other cycle.
- R8: When `fis_send_o` is high, `fis_o` holds the FIS. Byte n is at bits [8n+7:8n], and the bytes are:
  - byte 0: 0x27
  - byte 1: 0x80
  - byte 2: the command byte just written
  - byte 3: features newest
  - bytes 4, 5, 6: LBA low, mid and high newest
  - byte 7: device
  - bytes 8, 9, 10: LBA low, mid and high older
  - byte 11: features older
  - byte 12: count newest
  - byte 13: count older
  - byte 15: device control
  - bytes 14 and 16..19: zero
- R9: A synchronous reset clears every stored byte, both FIFO entries, the select bit, `fis_o` and `fis_send_o` to zero.
- R10: Writes to addresses outside the decoded map, including base offset 0, change no state. Reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_i | input | 1 | Write strobe for one cycle |
| io_addr_i | input | ADDR_W (16) | I/O address of the access |
| io_wdata_i | input | 8 | Write byte |
| io_rdata_o | output | 8 | Combinational read byte for `io_addr_i` |
| fis_send_o | output | 1 | One-cycle strobe: `fis_o` carries a new FIS |
| fis_o | output | 160 | Host-to-device register FIS, byte n at bits [8n+7:8n] |

## Verification
Assertions check three things on every cycle. The first is the shift rule of each two-entry history, with both entries holding steady between writes. The second is that the select bit follows each control write. The third is that every send strobe was caused by a command write and carries that command byte, the type byte and the current control byte. Only the bench scenarios can show the following: reads picking the newer or older byte, the full byte placement of a 48-bit command in the FIS, the address map of both channel variants, and that unmapped writes leave the readable state untouched.

// File: rtl/tf_shadow_pkg.sv
package tf_shadow_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_HOB   = 5;
    localparam int FIS_BYTES = 20;
    localparam int FIS_W     = FIS_BYTES * BYTE_W;

    localparam logic [BYTE_W-1:0] FIS_TYPE_H2D = 8'h27;
    localparam logic [BYTE_W-1:0] FIS_CMD_FLAG = 8'h80;

    // FIS byte slots consumed by the link layer
    localparam int FB_TYPE     = 0;
    localparam int FB_FLAGS    = 1;
    localparam int FB_CMD      = 2;
    localparam int FB_FEAT     = 3;
    localparam int FB_LBA_LO   = 4;
    localparam int FB_LBA_MID  = 5;
    localparam int FB_LBA_HI   = 6;
    localparam int FB_DEV      = 7;
    localparam int FB_LBA_LO_X = 8;
    localparam int FB_LBA_MID_X= 9;
    localparam int FB_LBA_HI_X = 10;
    localparam int FB_FEAT_X   = 11;
    localparam int FB_CNT      = 12;
    localparam int FB_CNT_X    = 13;
    localparam int FB_CTRL     = 15;

    // history slot indices
    localparam int SLOT_FEAT = 0;
    localparam int SLOT_CNT  = 1;
    localparam int SLOT_LO   = 2;
    localparam int SLOT_MID  = 3;
    localparam int SLOT_HI   = 4;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_FEAT,
        REG_COUNT,
        REG_LBA_LO,
        REG_LBA_MID,
        REG_LBA_HI,
        REG_DEV,
        REG_CMD,
        REG_CTRL
    } tf_reg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] older;
        logic [BYTE_W-1:0] newest;
    } hob_pair_t;

    function automatic tf_reg_e offset_to_reg(input logic [2:0] off);
        case (off)
            3'd1:    return REG_FEAT;
            3'd2:    return REG_COUNT;
            3'd3:    return REG_LBA_LO;
            3'd4:    return REG_LBA_MID;
            3'd5:    return REG_LBA_HI;
            3'd6:    return REG_DEV;
            3'd7:    return REG_CMD;
            default: return REG_NONE;
        endcase
    endfunction

    function automatic tf_reg_e slot_reg(input int slot);
        case (slot)
            SLOT_FEAT: return REG_FEAT;
            SLOT_CNT:  return REG_COUNT;
            SLOT_LO:   return REG_LBA_LO;
            SLOT_MID:  return REG_LBA_MID;
            SLOT_HI:   return REG_LBA_HI;
            default:   return REG_NONE;
        endcase
    endfunction

    function automatic logic [FIS_W-1:0] build_h2d(
        input hob_pair_t [NUM_HOB-1:0] pairs,
        input logic [BYTE_W-1:0]       dev,
        input logic [BYTE_W-1:0]       cmd,
        input logic [BYTE_W-1:0]       ctrl
    );
        logic [FIS_W-1:0] f;
        f = '0;
        f[FB_TYPE*BYTE_W      +: BYTE_W] = FIS_TYPE_H2D;
        f[FB_FLAGS*BYTE_W     +: BYTE_W] = FIS_CMD_FLAG;
        f[FB_CMD*BYTE_W       +: BYTE_W] = cmd;
        f[FB_FEAT*BYTE_W      +: BYTE_W] = pairs[SLOT_FEAT].newest;
        f[FB_LBA_LO*BYTE_W    +: BYTE_W] = pairs[SLOT_LO].newest;
        f[FB_LBA_MID*BYTE_W   +: BYTE_W] = pairs[SLOT_MID].newest;
        f[FB_LBA_HI*BYTE_W    +: BYTE_W] = pairs[SLOT_HI].newest;
        f[FB_DEV*BYTE_W       +: BYTE_W] = dev;
        f[FB_LBA_LO_X*BYTE_W  +: BYTE_W] = pairs[SLOT_LO].older;
        f[FB_LBA_MID_X*BYTE_W +: BYTE_W] = pairs[SLOT_MID].older;
        f[FB_LBA_HI_X*BYTE_W  +: BYTE_W] = pairs[SLOT_HI].older;
        f[FB_FEAT_X*BYTE_W    +: BYTE_W] = pairs[SLOT_FEAT].older;
        f[FB_CNT*BYTE_W       +: BYTE_W] = pairs[SLOT_CNT].newest;
        f[FB_CNT_X*BYTE_W     +: BYTE_W] = pairs[SLOT_CNT].older;
        f[FB_CTRL*BYTE_W      +: BYTE_W] = ctrl;
        return f;
    endfunction

endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
    import tf_shadow_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_BASE = 16'h01F0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h03F6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output tf_reg_e           sel_o
);

    localparam int OFF_W = 3;

    logic in_cmd_block;

    assign in_cmd_block = (addr_i[ADDR_W-1:OFF_W] == CMD_BASE[ADDR_W-1:OFF_W]);

    always_comb begin
        if (in_cmd_block)
            sel_o = offset_to_reg(addr_i[OFF_W-1:0]);
        else if (addr_i == CTL_ADDR)
            sel_o = REG_CTRL;
        else
            sel_o = REG_NONE;
    end

endmodule

// File: rtl/tf_hob_fifo.sv
module tf_hob_fifo
    import tf_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              hob_sel,
    output hob_pair_t         pair_o,
    output logic [BYTE_W-1:0] rdata_o
);

    hob_pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (wr_en) begin
            pair_q.older  <= pair_q.newest;
            pair_q.newest <= wdata;
        end
    end

    assign pair_o  = pair_q;
    assign rdata_o = hob_sel ? pair_q.older : pair_q.newest;

    // R2: a write ages the newest byte and lands the new one
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pair_q.older == $past(pair_q.newest)) && (pair_q.newest == $past(wdata)));

    // R2: no write, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pair_q));

endmodule

// File: rtl/tf_fis_builder.sv
module tf_fis_builder
    import tf_shadow_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_wr,
    input  logic [BYTE_W-1:0]         cmd_byte,
    input  hob_pair_t [NUM_HOB-1:0]   pairs,
    input  logic [BYTE_W-1:0]         dev,
    input  logic [BYTE_W-1:0]         ctrl,
    output logic [FIS_W-1:0]          fis_o,
    output logic                      send_o
);

    logic [FIS_W-1:0] fis_q;
    logic             send_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fis_q  <= '0;
            send_q <= 1'b0;
        end else begin
            send_q <= cmd_wr;
            if (cmd_wr)
                fis_q <= build_h2d(pairs, dev, cmd_byte, ctrl);
        end
    end

    assign fis_o  = fis_q;
    assign send_o = send_q;

    // R8: every strobe carries the register FIS type and command flag
    p_fis_type_r8: assert property (@(posedge clk) disable iff (rst)
        send_q |-> (fis_q[FB_TYPE*BYTE_W +: BYTE_W] == FIS_TYPE_H2D)
                && (fis_q[FB_FLAGS*BYTE_W +: BYTE_W] == FIS_CMD_FLAG));

    // R8: FIS stays put between command writes
    p_fis_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(fis_q));

endmodule

// File: rtl/tf_shadow_bank.sv
module tf_shadow_bank
    import tf_shadow_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter bit SECONDARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic [7:0]        io_wdata_i,
    output logic [7:0]        io_rdata_o,
    output logic              fis_send_o,
    output logic [159:0]      fis_o
);

    localparam logic [ADDR_W-1:0] CMD_BASE = SECONDARY ? ADDR_W'(16'h0170) : ADDR_W'(16'h01F0);
    localparam logic [ADDR_W-1:0] CTL_ADDR = SECONDARY ? ADDR_W'(16'h0376) : ADDR_W'(16'h03F6);
    localparam int                HOB_BIT  = 7;

    tf_reg_e                  sel;
    hob_pair_t [NUM_HOB-1:0]  pairs;
    logic [BYTE_W-1:0]        hob_rd [NUM_HOB];
    logic [BYTE_W-1:0]        dev_q, cmd_q, ctrl_q;
    logic                     hob_sel;
    logic                     cmd_wr, ctrl_wr, dev_wr;

    tf_addr_decode #(
        .ADDR_W   (ADDR_W),
        .CMD_BASE (CMD_BASE),
        .CTL_ADDR (CTL_ADDR)
    ) u_decode (
        .addr_i (io_addr_i),
        .sel_o  (sel)
    );

    assign cmd_wr  = io_wr_i && (sel == REG_CMD);
    assign ctrl_wr = io_wr_i && (sel == REG_CTRL);
    assign dev_wr  = io_wr_i && (sel == REG_DEV);
    assign hob_sel = ctrl_q[HOB_BIT];

    for (genvar i = 0; i < NUM_HOB; i++) begin : g_hob
        tf_hob_fifo u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (io_wr_i && (sel == slot_reg(i))),
            .wdata   (io_wdata_i),
            .hob_sel (hob_sel),
            .pair_o  (pairs[i]),
            .rdata_o (hob_rd[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_q  <= '0;
            cmd_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (dev_wr)  dev_q  <= io_wdata_i;
            if (cmd_wr)  cmd_q  <= io_wdata_i;
            if (ctrl_wr) ctrl_q <= io_wdata_i;
        end
    end

    always_comb begin
        case (sel)
            REG_FEAT:    io_rdata_o = hob_rd[SLOT_FEAT];
            REG_COUNT:   io_rdata_o = hob_rd[SLOT_CNT];
            REG_LBA_LO:  io_rdata_o = hob_rd[SLOT_LO];
            REG_LBA_MID: io_rdata_o = hob_rd[SLOT_MID];
            REG_LBA_HI:  io_rdata_o = hob_rd[SLOT_HI];
            REG_DEV:     io_rdata_o = dev_q;
            REG_CMD:     io_rdata_o = cmd_q;
            REG_CTRL:    io_rdata_o = ctrl_q;
            default:     io_rdata_o = '0;
        endcase
    end

    tf_fis_builder u_fis (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_byte (io_wdata_i),
        .pairs    (pairs),
        .dev      (dev_q),
        .ctrl     (ctrl_q),
        .fis_o    (fis_o),
        .send_o   (fis_send_o)
    );

    // R5: select bit tracks bit 7 of each control write
    p_hob_follow_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (hob_sel == $past(io_wdata_i[HOB_BIT])));

    // R7: a strobe only follows a command write
    p_send_cause_r7: assert property (@(posedge clk) disable iff (rst)
        fis_send_o |-> $past(cmd_wr));

    // R8: the command byte in the FIS is the one the register now holds
    p_fis_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        fis_send_o |-> (fis_o[FB_CMD*BYTE_W +: BYTE_W] == cmd_q)
                    && (fis_o[FB_CTRL*BYTE_W +: BYTE_W] == ctrl_q));

endmodule

// File: tb/tf_shadow_bank_bench.sv
`timescale 1ns/1ps
module tf_shadow_bank_bench;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;   // write byte, or expected read byte
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 27;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 16'h01F2, 8'h11, 4'd2},  // R2
        '{1'b1, 16'h01F2, 8'h22, 4'd2},  // R2
        '{1'b0, 16'h01F2, 8'h22, 4'd3},  // R3 newest
        '{1'b1, 16'h03F6, 8'h80, 4'd5},  // R5 select on
        '{1'b0, 16'h01F2, 8'h11, 4'd4},  // R4 older
        '{1'b0, 16'h03F6, 8'h80, 4'd5},  // R5 readback
        '{1'b1, 16'h01F6, 8'hE0, 4'd6},  // R6
        '{1'b0, 16'h01F6, 8'hE0, 4'd6},  // R6 device ignores select
        '{1'b1, 16'h03F6, 8'h00, 4'd5},  // R5 select off
        '{1'b0, 16'h01F2, 8'h22, 4'd3},  // R3
        '{1'b1, 16'h01F2, 8'h33, 4'd2},  // R2
        '{1'b0, 16'h01F2, 8'h33, 4'd3},  // R3
        '{1'b1, 16'h03F6, 8'h80, 4'd5},  // R5
        '{1'b0, 16'h01F2, 8'h22, 4'd2},  // R2 aged byte
        '{1'b1, 16'h01F3, 8'hA1, 4'd2},  // R2
        '{1'b1, 16'h01F3, 8'hB2, 4'd2},  // R2
        '{1'b0, 16'h01F3, 8'hA1, 4'd4},  // R4
        '{1'b1, 16'h0171, 8'h55, 4'd10}, // R10 other channel
        '{1'b0, 16'h0171, 8'h00, 4'd10}, // R10
        '{1'b1, 16'h01F0, 8'h66, 4'd10}, // R10 offset 0
        '{1'b0, 16'h01F0, 8'h00, 4'd10}, // R10
        '{1'b0, 16'h01F3, 8'hA1, 4'd10}, // R10 untouched
        '{1'b0, 16'h01F1, 8'h00, 4'd4},  // R4 empty older slot
        '{1'b1, 16'h03F6, 8'h02, 4'd5},  // R5 bit7=0 clears select
        '{1'b0, 16'h03F6, 8'h02, 4'd5},  // R5
        '{1'b0, 16'h01F3, 8'hB2, 4'd3},  // R3
        '{1'b0, 16'h01F2, 8'h33, 4'd3}   // R3
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         io_wr = 1'b0;
    logic [15:0]  io_addr = '0;
    logic [7:0]   io_wdata = '0;
    logic [7:0]   io_rdata;
    logic         fis_send;
    logic [159:0] fis;

    logic         s_wr = 1'b0;
    logic [15:0]  s_addr = '0;
    logic [7:0]   s_wdata = '0;
    logic [7:0]   s_rdata;
    logic         s_send;
    logic [159:0] s_fis;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tf_shadow_bank u_tf_shadow_bank (
        .clk(clk), .rst(rst), .io_wr_i(io_wr), .io_addr_i(io_addr),
        .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
        .fis_send_o(fis_send), .fis_o(fis)
    );

    tf_shadow_bank #(.SECONDARY(1'b1)) u_tf_shadow_bank_sec (
        .clk(clk), .rst(rst), .io_wr_i(s_wr), .io_addr_i(s_addr),
        .io_wdata_i(s_wdata), .io_rdata_o(s_rdata),
        .fis_send_o(s_send), .fis_o(s_fis)
    );

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        io_addr = a;
        #1;
        check(req, {152'd0, io_rdata}, {152'd0, exp});
    endtask

    task automatic swr(input logic [15:0] a, input logic [7:0] d);
        s_addr = a; s_wdata = d; s_wr = 1'b1;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    task automatic srd_chk(input logic [15:0] a, input logic [7:0] exp);
        s_addr = a;
        #1;
        check("R1", {152'd0, s_rdata}, {152'd0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_cleared();
        // R9: everything reads zero after reset
        check("R9", {159'd0, fis_send}, 160'd0);
        check("R9", fis, 160'd0);
        for (int a = 1; a < 8; a++) rd_chk("R9", 16'h01F0 + 16'(a), 8'h00);
        rd_chk("R9", 16'h03F6, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] exp_b [20];
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_cleared();

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d step%0d", VEC[i].req, i);
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else           rd_chk(tag, VEC[i].addr, VEC[i].data);
        end

        // R9: reset clears history, including the older slots
        do_reset();
        check_cleared();
        wr(16'h03F6, 8'h80);
        rd_chk("R9", 16'h01F2, 8'h00);
        rd_chk("R9", 16'h01F5, 8'h00);

        // 48-bit command load, expanded half first
        wr(16'h01F1, 8'hF1); wr(16'h01F1, 8'hF2);
        wr(16'h01F2, 8'hC1); wr(16'h01F2, 8'hC2);
        check("R7", {159'd0, fis_send}, 160'd0);  // R7 no strobe on other writes
        wr(16'h01F3, 8'h01); wr(16'h01F3, 8'h02);
        wr(16'h01F4, 8'h03); wr(16'h01F4, 8'h04);
        wr(16'h01F5, 8'h05); wr(16'h01F5, 8'h06);
        wr(16'h01F6, 8'hE0);
        wr(16'h03F6, 8'h08);
        wr(16'h01F7, 8'h25);
        check("R7", {159'd0, fis_send}, 160'd1);  // R7 strobe after command edge

        for (int b = 0; b < 20; b++) exp_b[b] = 8'h00;
        exp_b[0] = 8'h27; exp_b[1] = 8'h80; exp_b[2] = 8'h25;
        exp_b[3] = 8'hF2; exp_b[4] = 8'h02; exp_b[5] = 8'h04; exp_b[6] = 8'h06;
        exp_b[7] = 8'hE0; exp_b[8] = 8'h01; exp_b[9] = 8'h03; exp_b[10] = 8'h05;
        exp_b[11] = 8'hF1; exp_b[12] = 8'hC2; exp_b[13] = 8'hC1; exp_b[15] = 8'h08;
        for (int b = 0; b < 20; b++)
            check($sformatf("R8 byte%0d", b), {152'd0, fis[b*8 +: 8]}, {152'd0, exp_b[b]});

        @(negedge clk);
        check("R7", {159'd0, fis_send}, 160'd0);  // R7 single cycle

        // R6: command and device reads ignore the select bit
        rd_chk("R6", 16'h01F7, 8'h25);
        wr(16'h03F6, 8'h88);
        rd_chk("R6", 16'h01F7, 8'h25);
        rd_chk("R6", 16'h01F6, 8'hE0);
        rd_chk("R4", 16'h01F4, 8'h03);

        // R7: back-to-back commands give a strobe each
        wr(16'h01F7, 8'hEC);
        check("R7", {159'd0, fis_send}, 160'd1);
        wr(16'h01F7, 8'h24);
        check("R7", {159'd0, fis_send}, 160'd1);
        check("R8", {152'd0, fis[23:16]}, {152'd0, 8'h24});
        @(negedge clk);
        check("R7", {159'd0, fis_send}, 160'd0);

        // R1: secondary channel map
        swr(16'h0172, 8'h7A); swr(16'h0172, 8'h7B);
        srd_chk(16'h0172, 8'h7B);
        swr(16'h03F6, 8'h80);            // primary control address: ignored
        srd_chk(16'h0172, 8'h7B);
        swr(16'h0376, 8'h80);
        srd_chk(16'h0172, 8'h7A);
        srd_chk(16'h0376, 8'h80);
        swr(16'h0177, 8'h35);
        check("R1", {159'd0, s_send}, 160'd1);
        check("R1", {152'd0, s_fis[103:96]}, {152'd0, 8'h7B});

        finish_run();
    end

endmodule